// File: doc/BRIEF.md
# Burst Bus Master with Stall Insertion

This block is a bus master for an AHB-Lite style pipelined bus. It takes one command at a time from a valid/ready command port and turns it into a single transfer or a burst. Each command carries a start address, a direction, a transfer size, a burst kind and a beat count. The block drives the address and control of each beat in its address phase. It drives write data in the data phase that follows. It hands read data back with a valid strobe.

A stall input lets the user of the block pause a burst between beats. While stall is high in the middle of a burst, the block puts BUSY cycles on the bus, and the address and control shown during those cycles already belong to the next beat. An undefined-length burst can finish with one trailing BUSY cycle. The block inserts nothing while the bus holds the current phase with ready low. It drives IDLE whenever it has no work.

Top module: `burst_bus_master`

## Requirements
- R1: During reset and on the first cycle after it, the transfer type is IDLE (2'b00), and both `rd_valid_o` and `wr_take_o` are low.
- R2: The transfer type uses the codes IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10 and SEQ=2'b11. The master shows IDLE whenever no command or burst beat is pending.
- R3: A command is accepted on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both high. On the next cycle the bus shows NONSEQ, with the command's address, direction and size.
- R4: Each later beat is SEQ. Its address is the previous beat's address plus 2^size bytes, and direction, size and burst code do not change within the burst. Kind 0 (single) issues one beat. Kinds 1, 2 and 3 issue `cmd_len_i` beats.
- R5: In a wrapping burst (kind 2), the address wraps inside an aligned window of `cmd_len_i` × 2^size bytes.
- R6: When `stall_i` is high on an edge that ends a beat's address phase, and beats remain, the next cycle shows BUSY. BUSY repeats while `stall_i` stays high. BUSY cycles show the next beat's address and control and do not count as beats.
- R7: For kind 1 (undefined-length incrementing), `stall_i` high on the edge that accepts the final beat gives exactly one trailing BUSY cycle, followed by IDLE. For the other kinds, the bus goes to IDLE after the final beat and stall has no effect.
- R8: While `bus_ready_i` is low, address, transfer type, control and `bus_wdata_o` hold their values.
- R9: `wr_take_o` is high when a write beat's address phase completes (a beat type with ready high). The `wr_data_i` sampled on that edge appears on `bus_wdata_o` for the whole data phase that follows.
- R10: `rd_valid_o` is high exactly when `bus_ready_i` is high in the data phase of a read beat, with `rd_data_o` equal to `bus_rdata_i`. A cycle whose data phase follows a BUSY or IDLE address phase never strobes.
- R11: The burst code is 3'b000 for single and 3'b001 for undefined-length. For wrapping bursts it is 3'b010, 3'b100 and 3'b110 for 4, 8 and 16 beats. For fixed incrementing bursts it is 3'b011, 3'b101 and 3'b111 for 4, 8 and 16 beats.
- R12: `stall_i` high while no burst is in progress keeps `cmd_ready_o` low and the bus IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command taken on this edge if valid |
| cmd_addr_i | input | ADDR_W | Start address, aligned to the size |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_size_i | input | 3 | log2 of the bytes per beat |
| cmd_kind_i | input | 2 | 0 single, 1 undefined-length incr, 2 wrap, 3 fixed incr |
| cmd_len_i | input | LEN_W | Beat count (4, 8 or 16 for kinds 2 and 3) |
| stall_i | input | 1 | Request BUSY before the next beat |
| wr_data_i | input | DATA_W | Data for the write beat now in address phase |
| wr_take_o | output | 1 | `wr_data_i` consumed on this edge |
| rd_valid_o | output | 1 | Read beat completes this cycle |
| rd_data_o | output | DATA_W | Read data |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_trans_o | output | 2 | Transfer type |
| bus_write_o | output | 1 | Bus direction |
| bus_size_o | output | 3 | Bus transfer size |
| bus_burst_o | output | 3 | Bus burst code |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rdata_i | input | DATA_W | Bus read data |
| bus_ready_i | input | 1 | Bus ready; low extends the current phases |

## Verification
A wrong beat counter shows up on the bus as an extra or missing SEQ beat, or a wrong trailing cycle, once the final beat is accepted. A stale address register shows up as a BUSY or SEQ address that differs from the expected beat address, on the first beat after a stall or wrap. A data-phase flag that is out of step shows up as a read strobe or a write data mismatch one cycle after the address phase it belongs to. The bench compares every shown cycle against per-beat addresses computed from the command. It also checks the next transfer type predicted from stall and ready, so most faults are reported within one or two cycles.

// File: rtl/bmst_pkg.sv
package bmst_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    K_SINGLE = 2'd0,
    K_UNDEF  = 2'd1,
    K_WRAP   = 2'd2,
    K_FIXED  = 2'd3
  } kind_e;
endpackage

// File: rtl/bmst_addr_step.sv
module bmst_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [2:0]        size_i,
  input  logic              wrap_i,
  input  logic [ADDR_W-1:0] wrap_mask_i,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  logic [ADDR_W-1:0] inc, sum;

  assign inc = ADDR_W'(1) << size_i;
  assign sum = cur_addr_i + inc;
  // wrap keeps the window base, replaces the offset
  assign nxt_addr_o = wrap_i ? ((cur_addr_i & ~wrap_mask_i) | (sum & wrap_mask_i)) : sum;
endmodule

// File: rtl/bmst_seq.sv
module bmst_seq
  import bmst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              stall_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_write_i,
  input  logic [2:0]        cmd_size_i,
  input  logic [1:0]        cmd_kind_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [ADDR_W-1:0] nxt_addr_i,
  output logic [1:0]        trans_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [2:0]        size_o,
  output logic [2:0]        burst_o,
  output logic              wrap_o,
  output logic [ADDR_W-1:0] wrap_mask_o
);
  trans_e            trans_q;
  logic [ADDR_W-1:0] addr_q, mask_q;
  logic              write_q, wrap_q, undef_q;
  logic [2:0]        size_q, burst_q;
  logic [LEN_W-1:0]  left_q;

  kind_e             kind;
  logic [LEN_W-1:0]  beats;
  logic [1:0]        len_code;
  logic [2:0]        burst_d;
  logic              beat_shown, more, tail_busy, load;

  assign kind       = kind_e'(cmd_kind_i);
  assign beats      = (kind == K_SINGLE || cmd_len_i == '0) ? LEN_W'(1) : cmd_len_i;
  assign len_code   = (cmd_len_i == LEN_W'(16)) ? 2'd3 : (cmd_len_i == LEN_W'(8)) ? 2'd2 : 2'd1;

  always_comb begin
    unique case (kind)
      K_SINGLE: burst_d = 3'b000;
      K_UNDEF:  burst_d = 3'b001;
      K_WRAP:   burst_d = {len_code, 1'b0};
      default:  burst_d = {len_code, 1'b1};
    endcase
  end

  assign beat_shown  = (trans_q == TR_NSEQ) || (trans_q == TR_SEQ);
  assign more        = (left_q != '0);
  assign tail_busy   = beat_shown && !more && undef_q && stall_i;
  assign cmd_ready_o = ready_i && !more && !tail_busy && !stall_i;
  assign load        = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trans_q <= TR_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      write_q <= 1'b0;
      wrap_q  <= 1'b0;
      undef_q <= 1'b0;
      size_q  <= '0;
      burst_q <= '0;
      left_q  <= '0;
    end else if (ready_i) begin
      if (more) begin
        if (beat_shown) addr_q <= nxt_addr_i;  // after BUSY the next address is already shown
        trans_q <= stall_i ? TR_BUSY : TR_SEQ;
        if (!stall_i) left_q <= left_q - LEN_W'(1);
      end else if (tail_busy) begin
        addr_q  <= nxt_addr_i;
        trans_q <= TR_BUSY;
      end else if (load) begin
        trans_q <= TR_NSEQ;
        addr_q  <= cmd_addr_i;
        write_q <= cmd_write_i;
        size_q  <= cmd_size_i;
        burst_q <= burst_d;
        wrap_q  <= (kind == K_WRAP);
        undef_q <= (kind == K_UNDEF);
        mask_q  <= (ADDR_W'(beats) << cmd_size_i) - ADDR_W'(1);
        left_q  <= beats - LEN_W'(1);
      end else begin
        trans_q <= TR_IDLE;
      end
    end
  end

  assign trans_o     = trans_q;
  assign addr_o      = addr_q;
  assign write_o     = write_q;
  assign size_o      = size_q;
  assign burst_o     = burst_q;
  assign wrap_o      = wrap_q;
  assign wrap_mask_o = mask_q;

  a_r8_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(trans_q) && $stable(addr_q) && $stable(write_q) && $stable(size_q) && $stable(burst_q));

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (trans_q == TR_NSEQ) && (addr_q == $past(cmd_addr_i)));

  a_r4_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && beat_shown && more && !stall_i && !wrap_q)
      |=> (trans_q == TR_SEQ) && (addr_q == $past(addr_q) + (ADDR_W'(1) << size_q)));

  a_r4_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_q == TR_SEQ || trans_q == TR_BUSY) |-> $stable(write_q) && $stable(size_q) && $stable(burst_q));

  a_r6_busy_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_q == TR_BUSY) |-> ($past(trans_q) != TR_IDLE));

  a_r7_tail_undef_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_q == TR_BUSY && burst_q != 3'b001) |-> more);
endmodule

// File: rtl/bmst_dphase.sv
module bmst_dphase #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_take_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              beat, d_read_q;
  logic [DATA_W-1:0] wdata_q;

  assign beat      = (trans_i == 2'b10) || (trans_i == 2'b11);
  assign wr_take_o = ready_i && beat && write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_read_q <= 1'b0;
      wdata_q  <= '0;
    end else if (ready_i) begin
      d_read_q <= beat && !write_i;
      if (wr_take_o) wdata_q <= wr_data_i;
    end
  end

  assign wdata_o    = wdata_q;
  assign rd_valid_o = d_read_q && ready_i;
  assign rd_data_o  = rdata_i;

  a_r10_no_strobe_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ready_i) && $past(trans_i) == 2'b01) |-> !rd_valid_o);

  a_r9_wdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(wdata_o));
endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_write_i,
  input  logic [2:0]        cmd_size_i,
  input  logic [1:0]        cmd_kind_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              stall_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_take_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_trans_o,
  output logic              bus_write_o,
  output logic [2:0]        bus_size_o,
  output logic [2:0]        bus_burst_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);
  logic [ADDR_W-1:0] nxt_addr, wrap_mask;
  logic              wrap;

  bmst_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (bus_ready_i),
    .stall_i     (stall_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_write_i (cmd_write_i),
    .cmd_size_i  (cmd_size_i),
    .cmd_kind_i  (cmd_kind_i),
    .cmd_len_i   (cmd_len_i),
    .nxt_addr_i  (nxt_addr),
    .trans_o     (bus_trans_o),
    .addr_o      (bus_addr_o),
    .write_o     (bus_write_o),
    .size_o      (bus_size_o),
    .burst_o     (bus_burst_o),
    .wrap_o      (wrap),
    .wrap_mask_o (wrap_mask)
  );

  bmst_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr_i  (bus_addr_o),
    .size_i      (bus_size_o),
    .wrap_i      (wrap),
    .wrap_mask_i (wrap_mask),
    .nxt_addr_o  (nxt_addr)
  );

  bmst_dphase #(.DATA_W(DATA_W)) u_dphase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (bus_ready_i),
    .trans_i    (bus_trans_o),
    .write_i    (bus_write_o),
    .wr_data_i  (wr_data_i),
    .wr_take_o  (wr_take_o),
    .wdata_o    (bus_wdata_o),
    .rdata_i    (bus_rdata_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: tb/burst_bus_master_bench.sv
module burst_bus_master_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic [2:0]    cmd_size = '0;
  logic [1:0]    cmd_kind = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          stall = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_take, rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_trans;
  logic          bus_write;
  logic [2:0]    bus_size, bus_burst;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  // cross-cycle tracking
  logic [1:0]    exp_next = 2'b00;
  bit            d_rd = 0, d_wr = 0, prev_ready = 1;
  logic [DW-1:0] d_wval = '0, p_wdata = '0;
  logic [AW-1:0] p_addr = '0;
  logic [1:0]    p_trans = '0;

  burst_bus_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_burst_bus_master (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_addr_i(cmd_addr),
    .cmd_write_i(cmd_write), .cmd_size_i(cmd_size), .cmd_kind_i(cmd_kind), .cmd_len_i(cmd_len),
    .stall_i(stall), .wr_data_i(wr_data), .wr_take_o(wr_take),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .bus_addr_o(bus_addr), .bus_trans_o(bus_trans), .bus_write_o(bus_write),
    .bus_size_o(bus_size), .bus_burst_o(bus_burst), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] start, input int size,
                                               input int kind, input int len, input int k);
    longint span, base, off, s;
    s = longint'(start);
    if (kind == 2) begin
      span = longint'(len) << size;
      base = s - (s % span);
      off  = (s - base + (longint'(k) << size)) % span;
      return AW'(base + off);
    end
    return AW'(s + (longint'(k) << size));
  endfunction

  function automatic logic [2:0] exp_burst(input int kind, input int len);
    int lc;
    lc = (len == 16) ? 3 : (len == 8) ? 2 : 1;
    case (kind)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'(lc << 1);
      default: return 3'((lc << 1) | 1);
    endcase
  endfunction

  function automatic logic [DW-1:0] wbeat(input int id, input int k);
    return 32'hC0DE_0000 ^ DW'(id << 8) ^ DW'(k * 32'h0001_0011);
  endfunction

  task automatic run_cmd(input int id, input logic [AW-1:0] addr, input bit write, input int size,
                         input int kind, input int len, input int ready_pct, input int stall_pct,
                         input bit stall_last, input int pre_stall);
    int  nb, beat, cyc;
    bit  acc, done;
    logic [1:0] tr;
    string sq;
    nb = (kind == 0) ? 1 : len;
    beat = 0; cyc = 0; acc = 0; done = 0;
    sq = (kind == 2) ? "R5" : "R4";
    while (!done) begin
      @(negedge clk);
      cyc++;
      tr = bus_trans;
      cmd_valid = !acc;
      cmd_addr = addr; cmd_write = write; cmd_size = 3'(size);
      cmd_kind = 2'(kind); cmd_len = LW'(len);
      bus_ready = ($urandom_range(99) < 32'(ready_pct));
      stall = ($urandom_range(99) < 32'(stall_pct)) ||
              (stall_last && beat == nb - 1 && tr[1]) || (!acc && cyc <= pre_stall);
      bus_rdata = $urandom();
      wr_data = wbeat(id, beat);
      #1;
      // transfer type predicted on the previous edge
      check(bus_trans == exp_next,
            (exp_next == 2'b01) ? ((beat == nb && acc) ? "R7" : "R6") :
            (exp_next == 2'b11) ? "R4" : (exp_next == 2'b10) ? "R3" : "R2",
            "transfer type", 64'(bus_trans), 64'(exp_next));
      if (tr == 2'b10) begin
        check(bus_addr == addr, "R3", "first address", 64'(bus_addr), 64'(addr));
        check(bus_write == write && bus_size == 3'(size), "R3", "first control",
              64'({bus_write, bus_size}), 64'({write, 3'(size)}));
        check(bus_burst == exp_burst(kind, len), "R11", "burst code",
              64'(bus_burst), 64'(exp_burst(kind, len)));
      end
      if (tr == 2'b11 || tr == 2'b01) begin
        logic [AW-1:0] ea;
        ea = beat_addr(addr, size, kind, len, beat);
        check(bus_addr == ea, (tr == 2'b01) ? "R6" : sq, "beat address", 64'(bus_addr), 64'(ea));
        check(bus_write == write && bus_size == 3'(size) && bus_burst == exp_burst(kind, len),
              "R4", "control held", 64'({bus_write, bus_size, bus_burst}),
              64'({write, 3'(size), exp_burst(kind, len)}));
      end
      if (!prev_ready)
        check(bus_addr == p_addr && bus_trans == p_trans && bus_wdata == p_wdata, "R8",
              "hold while not ready", 64'(bus_addr), 64'(p_addr));
      check(rd_valid == (d_rd && bus_ready), "R10", "read strobe", 64'(rd_valid), 64'(d_rd && bus_ready));
      if (rd_valid) check(rd_data == bus_rdata, "R10", "read data", 64'(rd_data), 64'(bus_rdata));
      if (d_wr) check(bus_wdata == d_wval, "R9", "write data", 64'(bus_wdata), 64'(d_wval));
      check(wr_take == (bus_ready && tr[1] && write), "R9", "take strobe",
            64'(wr_take), 64'(bus_ready && tr[1] && write));
      if (!acc && tr == 2'b00) begin
        check(cmd_ready == (bus_ready && !stall), stall ? "R12" : "R3", "command ready",
              64'(cmd_ready), 64'(bus_ready && !stall));
      end
      // predict next cycle
      if (bus_ready) begin
        d_rd = tr[1] && !write;
        d_wr = tr[1] && write;
        if (d_wr) d_wval = wbeat(id, beat);
        if (!acc) begin
          if (tr == 2'b00 && !stall) begin acc = 1; exp_next = 2'b10; end
          else exp_next = 2'b00;
        end else if (tr[1]) begin
          beat++;
          if (beat < nb) exp_next = stall ? 2'b01 : 2'b11;
          else exp_next = (kind == 1 && stall) ? 2'b01 : 2'b00;
        end else if (tr == 2'b01) begin
          exp_next = (beat < nb) ? (stall ? 2'b01 : 2'b11) : 2'b00;
        end else begin
          exp_next = 2'b00;
          if (beat == nb) done = 1;
        end
      end else begin
        exp_next = tr;
      end
      prev_ready = bus_ready;
      p_addr = bus_addr; p_trans = bus_trans; p_wdata = bus_wdata;
      if (cyc > 3000) begin
        check(0, "R2", "burst never finished", 64'(beat), 64'(nb));
        done = 1;
      end
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1BAD_5EED));
    bus_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_trans == 2'b00 && !rd_valid && !wr_take, "R1", "in reset",
          64'({bus_trans, rd_valid, wr_take}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_trans == 2'b00 && !rd_valid && !wr_take, "R1", "after reset",
          64'({bus_trans, rd_valid, wr_take}), 64'(0));

    run_cmd(1, 32'h0000_0100, 1, 2, 0, 1, 100, 0, 0, 0);    // single write
    run_cmd(2, 32'h0000_0038, 0, 2, 2, 4, 100, 0, 0, 0);    // wrap4: 38 3C 30 34
    run_cmd(3, 32'h0000_1006, 1, 1, 2, 8, 100, 30, 0, 0);   // wrap8 halfword, stalls
    run_cmd(4, 32'h0000_2000, 0, 0, 3, 16, 50, 0, 0, 0);    // incr16 byte, wait states
    run_cmd(5, 32'h0000_3000, 1, 2, 1, 5, 100, 0, 1, 0);    // R7 trailing BUSY
    run_cmd(6, 32'h0000_4000, 0, 2, 3, 4, 100, 0, 1, 0);    // R7 no trailing BUSY
    run_cmd(7, 32'h0000_5000, 0, 2, 0, 1, 100, 0, 0, 3);    // R12 stall holds command
    run_cmd(8, 32'h0000_6010, 0, 2, 1, 1, 80, 0, 1, 0);     // undefined one beat + tail
    run_cmd(9, 32'h0000_7FF0, 1, 2, 2, 16, 70, 40, 0, 0);   // wrap16 with stalls/waits

    for (int i = 0; i < 60; i++) begin
      int kind, len, size, rp, sp;
      logic [AW-1:0] a;
      kind = int'($urandom_range(3));
      size = int'($urandom_range(2));
      case (kind)
        0: len = 1;
        1: len = int'($urandom_range(12, 1));
        default: len = 4 << $urandom_range(2);
      endcase
      a  = ($urandom() & 32'h000F_FFFF) & ~((32'd1 << size) - 1);
      rp = int'($urandom_range(100, 55));
      sp = int'($urandom_range(40));
      run_cmd(100 + i, a, bit'($urandom_range(1)), size, kind, len, rp, sp,
              bit'($urandom_range(1)), int'($urandom_range(2)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule